// File: doc/BRIEF.md
# IO Page Table Cache Invalidator

This block removes stale I/O page table entries from a small translation cache. Software describes a range of 8-byte page table entries in one 64-bit command word: an entry count, the entry-aligned physical address of the first entry, and a busy flag. Writing that word with the busy flag set starts a scan. The engine visits one cache line per clock, drops each valid line whose stored entry address lies inside the range, and clears the busy flag when the last line has been visited. Software polls the busy flag through the read-back path.

The cache itself is modelled as a tagged array with one valid bit per line. A fill port loads a tag into a chosen line, and a probe port reports whether any valid line holds a given tag. Together they let the surrounding logic, and the bench, observe which lines an invalidation removed.

Top module: `ptc_inval_engine`

## Requirements
- R1: After reset the busy flag is 0, the read-back word is all zeros and no probe tag hits.
- R2: The read-back word carries the stored count in bits 63:53, the stored entry index (byte address bits 41:3) in bits 41:3, the live busy flag in bit 0, and zeros in bits 52:42 and 2:1.
- R3: A command write with bit 0 set while idle raises busy on the next cycle, and busy then stays at 1 for exactly LINES cycles.
- R4: A command write with bit 0 clear while idle updates the stored count and address, leaves busy at 0, and invalidates no line.
- R5: Command writes while busy is 1 are ignored: the stored count and address, and the scan, are unaffected.
- R6: A scan clears the valid bit of every line whose tag t satisfies start <= t < start + n, where n is the entry count; all other lines keep their valid bit and tag.
- R7: A count field of 0 means 2048 entries.
- R8: A fill loads its tag into the addressed line and sets it valid when idle; fills while busy is 1 are ignored.
- R9: The range end is computed without wrapping, so a range near the top of the 39-bit entry index space never reaches low tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 64 | Command word written |
| cmd_rd_data | output | 64 | Command register read-back with live busy flag |
| fill_en | input | 1 | Load a tag into a cache line |
| fill_line | input | $clog2(LINES) | Line index for the fill |
| fill_tag | input | 39 | Entry index stored by the fill |
| probe_tag | input | 39 | Entry index looked up |
| probe_hit | output | 1 | A valid line holds probe_tag |

## Verification
A wrong scan counter shows up at once on the busy flag: the bench counts busy cycles per command and expects exactly the line count, so an off-by-one terminal value or a missed start is visible on the first command. A faulty range compare or bound leaves a wrong set of lines valid, which the probe port exposes line by line as soon as the scan ends; sweeps over tag spacing, start offset and count place lines just below, at, and just past both range ends. Leaks through the busy guard on writes or fills appear as a changed read-back word or an unexpected probe hit right after the command finishes.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int CMD_W     = 64;
    localparam int ENT_W     = 39;
    localparam int CNT_W     = 11;
    localparam int CNT_LSB   = 53;
    localparam int ENT_LSB   = 3;
    localparam int SPAN_W    = ENT_W + 1;
    localparam int MAX_SPAN  = 1 << CNT_W;

    typedef logic [ENT_W-1:0]  ent_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SPAN_W-1:0] span_t;

    typedef struct packed {
        cnt_t count;
        ent_t start;
    } cmd_fields_t;

    typedef struct packed {
        span_t lo;
        span_t hi;
    } range_t;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_SCAN = 1'b1
    } eng_state_t;

    function automatic cmd_fields_t unpack_cmd(input logic [CMD_W-1:0] w);
        cmd_fields_t f;
        f.count = w[CNT_LSB +: CNT_W];
        f.start = w[ENT_LSB +: ENT_W];
        return f;
    endfunction

    function automatic logic [CMD_W-1:0] pack_cmd(input cmd_fields_t f, input logic busy);
        logic [CMD_W-1:0] w;
        w = '0;
        w[CNT_LSB +: CNT_W] = f.count;
        w[ENT_LSB +: ENT_W] = f.start;
        w[0] = busy;
        return w;
    endfunction

    function automatic span_t span_len(input cnt_t c);
        span_t n;
        if (c == '0) n = span_t'(MAX_SPAN);
        else         n = span_t'(c);
        return n;
    endfunction

    function automatic range_t make_range(input cmd_fields_t f);
        range_t r;
        r.lo = {1'b0, f.start};
        r.hi = {1'b0, f.start} + span_len(f.count);
        return r;
    endfunction

endpackage

// File: rtl/ptc_cmd_reg.sv
module ptc_cmd_reg
    import ptc_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_data,
    output cmd_fields_t       fields_q,
    output logic              busy,
    output logic [IDX_W-1:0]  scan_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    eng_state_t  state_q;
    logic        accept;
    logic        start_scan;

    assign accept     = wr_en && (state_q == ENG_IDLE);
    assign start_scan = accept && wr_data[0];
    assign busy       = (state_q == ENG_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (accept) begin
            fields_q <= unpack_cmd(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ENG_IDLE;
            scan_idx <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    scan_idx <= '0;
                    if (start_scan) state_q <= ENG_SCAN;
                end
                ENG_SCAN: begin
                    if (scan_idx == LAST_IDX) begin
                        state_q  <= ENG_IDLE;
                        scan_idx <= '0;
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptc_range_cmp.sv
module ptc_range_cmp
    import ptc_pkg::*;
(
    input  range_t rng,
    input  ent_t   tag,
    input  logic   tag_valid,
    output logic   drop
);
    span_t wide_tag;
    logic  above_lo;
    logic  below_hi;

    assign wide_tag = {1'b0, tag};
    assign above_lo = (wide_tag >= rng.lo);
    assign below_hi = (wide_tag <  rng.hi);
    assign drop     = tag_valid && above_lo && below_hi;

endmodule

// File: rtl/ptc_tag_array.sv
module ptc_tag_array
    import ptc_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_line,
    input  ent_t              fill_tag,
    input  logic              frozen,
    input  logic              drop_en,
    input  logic [IDX_W-1:0]  scan_idx,
    output ent_t              scan_tag,
    output logic              scan_valid,
    input  ent_t              probe_tag,
    output logic              probe_hit
);
    ent_t             tag_q   [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic do_fill;
        logic do_drop;

        assign do_fill = fill_en && !frozen && (fill_line == IDX_W'(g));
        assign do_drop = drop_en && (scan_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
            end else if (do_fill) begin
                tag_q[g]   <= fill_tag;
                valid_q[g] <= 1'b1;
            end else if (do_drop) begin
                valid_q[g] <= 1'b0;
            end
        end

        assign match[g] = valid_q[g] && (tag_q[g] == probe_tag);
    end

    assign scan_tag   = tag_q[scan_idx];
    assign scan_valid = valid_q[scan_idx];
    assign probe_hit  = |match;

endmodule

// File: rtl/ptc_inval_engine.sv
module ptc_inval_engine
    import ptc_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr_en,
    input  logic [63:0]       cmd_wr_data,
    output logic [63:0]       cmd_rd_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_line,
    input  logic [38:0]       fill_tag,
    input  logic [38:0]       probe_tag,
    output logic              probe_hit
);
    cmd_fields_t       fields_q;
    logic              busy;
    logic [IDX_W-1:0]  scan_idx;
    range_t            rng;
    ent_t              scan_tag;
    logic              scan_valid;
    logic              drop;

    ptc_cmd_reg #(.LINES(LINES)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd_wr_en),
        .wr_data  (cmd_wr_data),
        .fields_q (fields_q),
        .busy     (busy),
        .scan_idx (scan_idx)
    );

    assign rng = make_range(fields_q);

    ptc_range_cmp u_cmp (
        .rng       (rng),
        .tag       (scan_tag),
        .tag_valid (scan_valid),
        .drop      (drop)
    );

    ptc_tag_array #(.LINES(LINES)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_en),
        .fill_line  (fill_line),
        .fill_tag   (fill_tag),
        .frozen     (busy),
        .drop_en    (busy && drop),
        .scan_idx   (scan_idx),
        .scan_tag   (scan_tag),
        .scan_valid (scan_valid),
        .probe_tag  (probe_tag),
        .probe_hit  (probe_hit)
    );

    assign cmd_rd_data = pack_cmd(fields_q, busy);

endmodule

// File: rtl/ptc_inval_checker.sv
module ptc_inval_checker #(
    parameter int LINES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr_en,
    input logic [63:0] cmd_wr_data,
    input logic [63:0] cmd_rd_data,
    input logic [38:0] probe_tag,
    input logic        probe_hit
);
    localparam int CW = $clog2(LINES + 1) + 1;

    logic          busy;
    logic [CW-1:0] busy_cnt;

    assign busy = cmd_rd_data[0];

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (cmd_rd_data == 64'd0)); // R1

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd_data[52:42] == 11'd0) && (cmd_rd_data[2:1] == 2'd0)); // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr_en && !busy && cmd_wr_data[0]) |=> busy); // R3

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < CW'(LINES))); // R3

    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> (busy_cnt == CW'(LINES))); // R3

    AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr_en && !busy && !cmd_wr_data[0]) |=> !busy); // R4

    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_rd_data[63:1])); // R5

    AST_SCAN_ONLY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy && !probe_hit) |=> (!probe_hit || (probe_tag != $past(probe_tag)))); // R8

endmodule

bind ptc_inval_engine ptc_inval_checker #(.LINES(LINES)) u_ptc_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr_en   (cmd_wr_en),
    .cmd_wr_data (cmd_wr_data),
    .cmd_rd_data (cmd_rd_data),
    .probe_tag   (probe_tag),
    .probe_hit   (probe_hit)
);

// File: tb/test_ptc_inval_engine.sv
module test_ptc_inval_engine;

    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);
    localparam longint unsigned TOP = (64'd1 << 39);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_wr_en = 1'b0;
    logic [63:0]       cmd_wr_data = '0;
    logic [63:0]       cmd_rd_data;
    logic              fill_en = 1'b0;
    logic [IDX_W-1:0]  fill_line = '0;
    logic [38:0]       fill_tag = '0;
    logic [38:0]       probe_tag = '0;
    logic              probe_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    longint unsigned m_tag [LINES];
    bit              m_val [LINES];

    always #10 clk = ~clk;

    ptc_inval_engine #(.LINES(LINES)) i_ptc_inval_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr_en   (cmd_wr_en),
        .cmd_wr_data (cmd_wr_data),
        .cmd_rd_data (cmd_rd_data),
        .fill_en     (fill_en),
        .fill_line   (fill_line),
        .fill_tag    (fill_tag),
        .probe_tag   (probe_tag),
        .probe_hit   (probe_hit)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_cmd(input int cnt, input longint unsigned start, input bit go);
        logic [63:0] w;
        w = '0;
        w[63:53] = cnt[10:0];
        w[41:3]  = start[38:0];
        w[0]     = go;
        return w;
    endfunction

    task automatic fill(input int line, input longint unsigned tag);
        @(negedge clk);
        fill_en = 1'b1; fill_line = IDX_W'(line); fill_tag = tag[38:0];
        @(negedge clk);
        fill_en = 1'b0;
        m_tag[line] = tag;
        m_val[line] = 1'b1;
    endtask

    function automatic bit exp_hit(input longint unsigned tag);
        for (int i = 0; i < LINES; i++)
            if (m_val[i] && m_tag[i] == tag) return 1'b1;
        return 1'b0;
    endfunction

    task automatic probe_all(input string req);
        for (int i = 0; i < LINES; i++) begin
            probe_tag = m_tag[i][38:0];
            #1;
            check(req, probe_hit, exp_hit(m_tag[i]));
        end
    endtask

    task automatic model_drop(input int cnt, input longint unsigned start);
        longint unsigned n;
        n = (cnt == 0) ? 2048 : cnt;
        for (int i = 0; i < LINES; i++)
            if (m_val[i] && m_tag[i] >= start && m_tag[i] < start + n) m_val[i] = 1'b0;
    endtask

    task automatic run_cmd(input int cnt, input longint unsigned start, input bit poke, input string req);
        int blen;
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_wr_data = mk_cmd(cnt, start, 1'b1);
        @(negedge clk);
        cmd_wr_en = 1'b0;
        check("R2", cmd_rd_data, mk_cmd(cnt, start, 1'b1));
        blen = 0;
        while (cmd_rd_data[0] && blen < 100) begin
            blen++;
            if (poke && blen == 3) begin
                cmd_wr_en = 1'b1; cmd_wr_data = mk_cmd(7, 64'h55, 1'b0);
                fill_en = 1'b1; fill_line = '0; fill_tag = 39'h7777;
            end else begin
                cmd_wr_en = 1'b0; fill_en = 1'b0;
            end
            @(negedge clk);
        end
        cmd_wr_en = 1'b0; fill_en = 1'b0;
        check("R3", blen, LINES);
        model_drop(cnt, start);
        if (poke) begin
            check("R5", cmd_rd_data, mk_cmd(cnt, start, 1'b0));
            probe_tag = 39'h7777; #1;
            check("R8", probe_hit, 1'b0);
        end
        probe_all(req);
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin m_tag[i] = 64'(i); m_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", cmd_rd_data, 64'd0);
        for (int i = 0; i < 4; i++) begin
            probe_tag = 39'(i * 5); #1;
            check("R1", probe_hit, 1'b0);
        end

        // fill and probe
        for (int i = 0; i < LINES; i++) fill(i, 64'h1000 + 64'(i));
        probe_all("R8");

        // idle write without start
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_wr_data = mk_cmd(3, 64'h1002, 1'b0);
        @(negedge clk);
        cmd_wr_en = 1'b0;
        check("R4", cmd_rd_data, mk_cmd(3, 64'h1002, 1'b0));
        repeat (LINES + 2) @(negedge clk);
        check("R4", cmd_rd_data[0], 1'b0);
        probe_all("R4");

        // sweep stride / start / count
        for (int s = 0; s < 3; s++) begin
            for (int o = -2; o <= 5; o += 7) begin
                for (int c = 1; c <= 9; c += 4) begin
                    int stride;
                    stride = (s == 0) ? 1 : (s == 1) ? 3 : 5;
                    for (int i = 0; i < LINES; i++) fill(i, 64'h2000 + 64'(i * stride));
                    run_cmd(c, 64'h2000 + 64'(o * stride), (s == 1 && c == 5), "R6");
                end
            end
        end

        // range boundaries exactly at the line tags
        for (int i = 0; i < LINES; i++) fill(i, 64'h3000 + 64'(i * 2));
        run_cmd(6, 64'h3004, 1'b0, "R6");

        // count 0 means 2048 entries
        for (int i = 0; i < LINES; i++) fill(i, 64'h10000 + 64'(i * 200));
        run_cmd(0, 64'h10000 + 64'd100, 1'b0, "R7");
        for (int i = 0; i < LINES; i++) fill(i, 64'h20000 + 64'(i * 256) - 64'd1024);
        run_cmd(0, 64'h20000, 1'b0, "R7");

        // top of space: no wrap to low tags
        for (int i = 0; i < 8; i++) fill(i, TOP - 8 + 64'(i));
        for (int i = 8; i < LINES; i++) fill(i, 64'(i - 8));
        run_cmd(20, TOP - 4, 1'b0, "R9");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule